// File: doc/BRIEF.md
# Load/Store Address Checker and Router

This block sits between a processor's load/store unit and its data memories. Each cycle it may accept one byte, halfword or word access with a 32-bit virtual address. It checks the alignment of the access and decodes the segment from the top three address bits. It then sends the access to one of three places. The first is an internal scratchpad that answers a fixed physical window. The second is main RAM, which is mirrored. The third is a read-only boot ROM. RAM and ROM share one downstream port.

The downstream target answers in the same cycle with read data and a bus-error flag. The router registers the outcome, so a result appears one clock after the request. That result is either a completion with zero-extended read data or an exception strobe with a 3-bit cause code. Only one cause is reported per access. An alignment fault also captures the offending virtual address.

Top module: `lsu_route`

## Requirements
- R1: A halfword access with address bit 0 set, or a word access with address bits [1:0] not 00, faults with code 1 on a read and code 2 on a write. No downstream request is issued and the scratchpad is not written.
- R2: `bad_addr` resets to 0. An alignment fault (code 1 or 2) loads it with the full virtual address. Every other outcome leaves it unchanged.
- R3: A byte access (`req_size` 0) never raises code 1 or 2, whatever its low address bits are.
- R4: The segment is `req_addr[31:29]`. Segments 1, 2, 3, 6 and 7 fault with code 3 and perform no access. Alignment faults win over this check.
- R5: In segments 0 and 4, the physical address is the address ANDed with 0x1FFF_FFFF. A physical address whose bits [28:10] equal those of 0x1F80_0000 is served by the 1 KiB scratchpad at offset bits [9:0], with no downstream request. In segment 5 the same window is not intercepted.
- R6: A physical address below 0x0080_0000 goes to RAM. `dn_rom` is 0 and `dn_addr` is the physical address ANDed with 0x001F_FFFF, so the RAM is mirrored.
- R7: Physical addresses from 0x1FC0_0000 up to but not including 0x1FC8_0000 belong to the ROM. Reads go downstream with `dn_rom` 1 and `dn_addr` equal to the physical address minus 0x1FC0_0000. Writes fault with code 5 and issue no request.
- R8: A physical address that none of R5 to R7 claims faults with code 6 and issues no request.
- R9: Read data is zero-extended: a byte fills bits [7:0] and a halfword fills bits [15:0]. Downstream data arrives right-justified in `dn_rdata`. The scratchpad is little-endian, so the byte at offset o sits in lane o mod 4. A completed write returns read data 0.
- R10: If `dn_berr` is high while `dn_req` is high, `dn_berr_clr` pulses in that same cycle and the access faults with code 4 instead of completing. `dn_berr` has no effect when there is no downstream request.
- R11: For each accepted request, exactly one of `rsp_valid` and `exc_valid` is high for one cycle, on the clock edge after the request. Both are 0 after reset and on idle cycles. Code 0 means no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Virtual address |
| req_wdata | input | 32 | Store data, right-justified |
| rsp_valid | output | 1 | Access completed without fault |
| rsp_rdata | output | 32 | Zero-extended load data |
| exc_valid | output | 1 | Exception strobe |
| exc_code | output | 3 | Exception cause code |
| bad_addr | output | 32 | Address of the last alignment fault |
| dn_req | output | 1 | Downstream access this cycle |
| dn_write | output | 1 | Downstream store |
| dn_rom | output | 1 | 1 = ROM target, 0 = RAM target |
| dn_size | output | 2 | Downstream access size |
| dn_addr | output | 32 | Offset within the selected target |
| dn_wdata | output | 32 | Downstream store data |
| dn_rdata | input | 32 | Downstream load data, same cycle |
| dn_berr | input | 1 | Downstream bus error flag |
| dn_berr_clr | output | 1 | Clears the downstream error flag |

## Verification
The downstream request fields and the error-clear pulse are combinational on the request, so the bench checks them one nanosecond after it drives a request on a falling edge, within the same cycle. The completion and exception strobes, the read data and the fault address come from registers loaded at the next rising edge. The bench checks them at the following falling edge, exactly one cycle after the request. Requests run back to back, so every check lands in a cycle that only one access can have produced. A read-back ahead of the random traffic confirms that idle cycles leave both strobes low.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
package lsr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [2:0] {
        XC_NONE     = 3'd0,
        XC_ALIGN_LD = 3'd1,
        XC_ALIGN_ST = 3'd2,
        XC_SEGMENT  = 3'd3,
        XC_BUS      = 3'd4,
        XC_ROM_WR   = 3'd5,
        XC_UNMAPPED = 3'd6
    } exc_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SPAD = 2'd1,
        TGT_RAM  = 2'd2,
        TGT_ROM  = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e        tgt;
        exc_e        fault;
        logic [31:0] phys;
    } route_t;

    // Misalignment by size; any size code above halfword follows word rules
    function automatic logic misaligned(input logic [1:0] sz, input logic [1:0] lo);
        case (sz)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = lo[0];
            default: misaligned = (lo != 2'b00);
        endcase
    endfunction

    function automatic logic seg_rejected(input logic [2:0] seg);
        seg_rejected = !(seg == 3'd0 || seg == 3'd4 || seg == 3'd5);
    endfunction

    function automatic logic seg_cached(input logic [2:0] seg);
        seg_cached = (seg == 3'd0 || seg == 3'd4);
    endfunction

    function automatic logic [3:0] lane_enables(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            SZ_BYTE: lane_enables = 4'b0001 << off;
            SZ_HALF: lane_enables = 4'b0011 << off;
            default: lane_enables = 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] zero_extend(input logic [31:0] d, input logic [1:0] sz);
        case (sz)
            SZ_BYTE: zero_extend = {24'b0, d[7:0]};
            SZ_HALF: zero_extend = {16'b0, d[15:0]};
            default: zero_extend = d;
        endcase
    endfunction

endpackage

// File: rtl/lsr_decode.sv
`timescale 1ns/1ps
module lsr_decode
    import lsr_pkg::*;
#(
    parameter logic [31:0] PA_MASK   = 32'h1FFF_FFFF,
    parameter logic [31:0] RAM_END   = 32'h0080_0000,
    parameter logic [31:0] ROM_BASE  = 32'h1FC0_0000,
    parameter logic [31:0] ROM_BYTES = 32'h0008_0000,
    parameter logic [31:0] SPAD_BASE = 32'h1F80_0000,
    parameter int unsigned SPAD_BYTES = 1024
) (
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    input  logic        write,
    output route_t      route
);

    localparam logic [31:0] SPAD_WIN = PA_MASK & ~(SPAD_BYTES - 32'd1);
    localparam logic [31:0] ROM_END  = ROM_BASE + ROM_BYTES;

    logic [31:0] phys;
    logic [2:0]  seg;
    logic        in_spad, in_ram, in_rom;

    assign phys    = addr & PA_MASK;
    assign seg     = addr[31:29];
    assign in_spad = seg_cached(seg) && ((phys & SPAD_WIN) == SPAD_BASE);
    assign in_ram  = phys < RAM_END;
    assign in_rom  = (phys >= ROM_BASE) && (phys < ROM_END);

    // Fixed priority: alignment, segment, scratchpad, RAM, ROM, unmapped
    always_comb begin
        route.phys  = phys;
        route.tgt   = TGT_NONE;
        route.fault = XC_NONE;
        if (misaligned(size, addr[1:0])) begin
            route.fault = write ? XC_ALIGN_ST : XC_ALIGN_LD;
        end else if (seg_rejected(seg)) begin
            route.fault = XC_SEGMENT;
        end else if (in_spad) begin
            route.tgt = TGT_SPAD;
        end else if (in_ram) begin
            route.tgt = TGT_RAM;
        end else if (in_rom) begin
            if (write) route.fault = XC_ROM_WR;
            else       route.tgt   = TGT_ROM;
        end else begin
            route.fault = XC_UNMAPPED;
        end
    end

    // A routed access never carries a fault, and a fault never names a target
    always_comb begin
        a_r11_route_or_fault: assert ((route.tgt == TGT_NONE) == (route.fault != XC_NONE))
            else $error("decode produced both or neither of target and fault");
    end

endmodule

// File: rtl/lsr_spad.sv
`timescale 1ns/1ps
module lsr_spad #(
    parameter int unsigned BYTES = 1024
) (
    input  logic                           clk,
    input  logic                           we,
    input  logic [3:0]                     be,
    input  logic [$clog2(BYTES/4)-1:0]     idx,
    input  logic [31:0]                    wdata,
    output logic [31:0]                    rdata
);

    localparam int unsigned WORDS = BYTES / 4;

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] mem [WORDS];

        always_ff @(posedge clk) begin
            if (we && be[g]) mem[idx] <= wdata[8*g +: 8];
        end

        assign rdata[8*g +: 8] = mem[idx];
    end

endmodule

// File: rtl/lsu_route.sv
`timescale 1ns/1ps
module lsu_route
    import lsr_pkg::*;
#(
    parameter logic [31:0] PA_MASK    = 32'h1FFF_FFFF,
    parameter logic [31:0] RAM_END    = 32'h0080_0000,
    parameter logic [31:0] RAM_BYTES  = 32'h0020_0000,
    parameter logic [31:0] ROM_BASE   = 32'h1FC0_0000,
    parameter logic [31:0] ROM_BYTES  = 32'h0008_0000,
    parameter logic [31:0] SPAD_BASE  = 32'h1F80_0000,
    parameter int unsigned SPAD_BYTES = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        exc_valid,
    output logic [2:0]  exc_code,
    output logic [31:0] bad_addr,
    output logic        dn_req,
    output logic        dn_write,
    output logic        dn_rom,
    output logic [1:0]  dn_size,
    output logic [31:0] dn_addr,
    output logic [31:0] dn_wdata,
    input  logic [31:0] dn_rdata,
    input  logic        dn_berr,
    output logic        dn_berr_clr
);

    localparam int unsigned SPAD_IW  = $clog2(SPAD_BYTES / 4);
    localparam logic [31:0] RAM_MASK = RAM_BYTES - 32'd1;

    route_t      route;
    logic [1:0]  off;
    logic        spad_we;
    logic [3:0]  spad_be;
    logic [31:0] spad_wdata, spad_rdata;
    logic [31:0] rd_next;
    exc_e        fault_next, code_q;

    lsr_decode #(
        .PA_MASK    (PA_MASK),
        .RAM_END    (RAM_END),
        .ROM_BASE   (ROM_BASE),
        .ROM_BYTES  (ROM_BYTES),
        .SPAD_BASE  (SPAD_BASE),
        .SPAD_BYTES (SPAD_BYTES)
    ) i_decode (
        .addr  (req_addr),
        .size  (req_size),
        .write (req_write),
        .route (route)
    );

    assign off        = route.phys[1:0];
    assign spad_we    = req_valid && req_write && (route.tgt == TGT_SPAD);
    assign spad_be    = lane_enables(req_size, off);
    assign spad_wdata = req_wdata << {off, 3'b000};

    lsr_spad #(.BYTES(SPAD_BYTES)) i_spad (
        .clk   (clk),
        .we    (spad_we),
        .be    (spad_be),
        .idx   (route.phys[SPAD_IW+1:2]),
        .wdata (spad_wdata),
        .rdata (spad_rdata)
    );

    // Downstream port: RAM and ROM share it, selected by dn_rom
    assign dn_req      = req_valid && (route.tgt == TGT_RAM || route.tgt == TGT_ROM);
    assign dn_write    = req_write;
    assign dn_rom      = (route.tgt == TGT_ROM);
    assign dn_size     = req_size;
    assign dn_wdata    = req_wdata;
    assign dn_addr     = dn_rom ? (route.phys - ROM_BASE) : (route.phys & RAM_MASK);
    assign dn_berr_clr = dn_req && dn_berr;

    always_comb begin
        fault_next = route.fault;
        if (dn_req && dn_berr) fault_next = XC_BUS;
    end

    always_comb begin
        if (req_write || fault_next != XC_NONE) rd_next = '0;
        else if (route.tgt == TGT_SPAD)         rd_next = zero_extend(spad_rdata >> {off, 3'b000}, req_size);
        else                                    rd_next = zero_extend(dn_rdata, req_size);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            exc_valid <= 1'b0;
            code_q    <= XC_NONE;
            rsp_rdata <= '0;
            bad_addr  <= '0;
        end else begin
            rsp_valid <= req_valid && (fault_next == XC_NONE);
            exc_valid <= req_valid && (fault_next != XC_NONE);
            code_q    <= req_valid ? fault_next : XC_NONE;
            rsp_rdata <= req_valid ? rd_next : '0;
            if (req_valid && (route.fault == XC_ALIGN_LD || route.fault == XC_ALIGN_ST))
                bad_addr <= req_addr;
        end
    end

    assign exc_code = code_q;

    // ---------------- assertions ----------------
    logic req_mis;
    assign req_mis = misaligned(req_size, req_addr[1:0]);

    a_r1_no_access: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_mis |-> !dn_req && !spad_we);

    a_r1_align_code: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_mis |=> exc_valid &&
            (exc_code == ($past(req_write) ? XC_ALIGN_ST : XC_ALIGN_LD)));

    a_r2_badaddr_only_on_align: assert property (@(posedge clk) disable iff (rst)
        !$stable(bad_addr) |-> exc_valid && (exc_code == XC_ALIGN_LD || exc_code == XC_ALIGN_ST));

    a_r3_byte_no_align: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_size == SZ_BYTE |=> !(exc_code == XC_ALIGN_LD || exc_code == XC_ALIGN_ST));

    a_r4_segment_blocks: assert property (@(posedge clk) disable iff (rst)
        req_valid && seg_rejected(req_addr[31:29]) |-> !dn_req && !spad_we);

    a_r7_rom_no_write: assert property (@(posedge clk) disable iff (rst)
        dn_req && dn_rom |-> !dn_write);

    a_r9_byte_zext: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && $past(req_size) == SZ_BYTE |-> rsp_rdata[31:8] == 24'b0);

    a_r10_bus_error: assert property (@(posedge clk) disable iff (rst)
        req_valid && dn_berr && dn_req |=> exc_valid && exc_code == XC_BUS && !rsp_valid);

    a_r11_one_outcome: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && exc_valid));

    a_r11_req_answered: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid || exc_valid);

endmodule

// File: tb/test_lsu_route.sv
`timescale 1ns/1ps
module test_lsu_route;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [1:0]  req_size;
    logic [31:0] req_addr, req_wdata;
    logic        rsp_valid, exc_valid;
    logic [31:0] rsp_rdata, bad_addr;
    logic [2:0]  exc_code;
    logic        dn_req, dn_write, dn_rom, dn_berr, dn_berr_clr;
    logic [1:0]  dn_size;
    logic [31:0] dn_addr, dn_wdata, dn_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0]  spad_m [1024];
    logic [31:0] bad_m = 32'h0;

    always #2.5 clk = ~clk;

    lsu_route i_lsu_route (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .exc_valid(exc_valid), .exc_code(exc_code), .bad_addr(bad_addr),
        .dn_req(dn_req), .dn_write(dn_write), .dn_rom(dn_rom), .dn_size(dn_size),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
        .dn_berr(dn_berr), .dn_berr_clr(dn_berr_clr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dn_pattern(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_F00F;
    endfunction

    // Target: 0 none, 1 scratchpad, 2 RAM, 3 ROM. Returns the pre-bus-error code.
    function automatic int model_code(input logic [31:0] a, input int sz, input bit wr, output int tgt);
        logic [31:0] p;
        logic [2:0]  s;
        p = a & 32'h1FFF_FFFF;
        s = a[31:29];
        tgt = 0;
        if ((sz == 1 && a[0]) || (sz == 2 && a[1:0] != 2'b00)) return wr ? 2 : 1;
        if (!(s == 0 || s == 4 || s == 5)) return 3;
        if ((s == 0 || s == 4) && p >= 32'h1F80_0000 && p < 32'h1F80_0400) begin tgt = 1; return 0; end
        if (p < 32'h0080_0000) begin tgt = 2; return 0; end
        if (p >= 32'h1FC0_0000 && p < 32'h1FC8_0000) begin
            if (wr) return 5;
            tgt = 3; return 0;
        end
        return 6;
    endfunction

    function automatic string tag_for(input int code, input int tgt, input int sz, input logic [31:0] a);
        case (code)
            1, 2: return "R1";
            3: return "R4";
            4: return "R10";
            5: return "R7";
            6: return "R8";
            default: ;
        endcase
        if (sz == 0 && a[0]) return "R3";
        if (tgt == 1) return "R5";
        if (tgt == 2) return "R6";
        return "R7";
    endfunction

    // Drive at a falling edge, check downstream fields 1 ns later, check registered results at the next falling edge
    task automatic txn(input logic [31:0] a, input int sz, input bit wr, input logic [31:0] wd, input bit berr);
        int tgt, code, fcode;
        bit exp_dn;
        logic [31:0] p, exp_rd, exp_da;
        string tg;
        code = model_code(a, sz, wr, tgt);
        p = a & 32'h1FFF_FFFF;
        req_valid = 1'b1; req_write = wr; req_size = 2'(sz); req_addr = a; req_wdata = wd;
        dn_rdata = dn_pattern(a); dn_berr = berr;
        #1;
        exp_dn = (code == 0) && (tgt == 2 || tgt == 3);
        fcode = (exp_dn && berr) ? 4 : code;
        tg = tag_for(fcode, tgt, sz, a);
        chk(dn_req === exp_dn, tg, {31'b0, dn_req}, {31'b0, exp_dn});
        if (exp_dn) begin
            exp_da = (tgt == 3) ? (p - 32'h1FC0_0000) : (p & 32'h001F_FFFF);
            chk(dn_addr === exp_da, tg, dn_addr, exp_da);
            chk(dn_rom === (tgt == 3), tg, {31'b0, dn_rom}, {31'b0, tgt == 3});
        end
        chk(dn_berr_clr === (exp_dn && berr), "R10", {31'b0, dn_berr_clr}, {31'b0, exp_dn && berr});
        exp_rd = 32'h0;
        if (fcode == 0 && !wr) begin
            if (tgt == 1) begin
                for (int i = 0; i < (1 << sz); i++)
                    exp_rd |= {24'b0, spad_m[p[9:0] + 10'(i)]} << (8 * i);
            end else begin
                exp_rd = dn_pattern(a);
                if (sz == 0) exp_rd &= 32'hFF;
                if (sz == 1) exp_rd &= 32'hFFFF;
            end
        end
        if (fcode == 0 && wr && tgt == 1)
            for (int i = 0; i < (1 << sz); i++) spad_m[p[9:0] + 10'(i)] = wd[8*i +: 8];
        if (fcode == 1 || fcode == 2) bad_m = a;
        @(negedge clk);
        chk(exc_valid === (fcode != 0), "R11", {31'b0, exc_valid}, {31'b0, fcode != 0});
        chk(rsp_valid === (fcode == 0), "R11", {31'b0, rsp_valid}, {31'b0, fcode == 0});
        if (fcode != 0) chk(exc_code === 3'(fcode), tg, {29'b0, exc_code}, 32'(fcode));
        else            chk(rsp_rdata === exp_rd, "R9", rsp_rdata, exp_rd);
        chk(bad_addr === bad_m, "R2", bad_addr, bad_m);
        req_valid = 1'b0; dn_berr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
        req_addr = '0; req_wdata = '0; dn_rdata = '0; dn_berr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 / R2: reset state and idle cycle
        chk(rsp_valid === 1'b0 && exc_valid === 1'b0, "R11", {30'b0, rsp_valid, exc_valid}, 32'h0);
        chk(bad_addr === 32'h0, "R2", bad_addr, 32'h0);

        // R5: fill the scratchpad through segment 0, word by word
        for (int w = 0; w < 256; w++)
            txn(32'h1F80_0000 + 32'(w * 4), 2, 1'b1, $urandom, 1'b0);
        @(negedge clk);
        chk(rsp_valid === 1'b0 && exc_valid === 1'b0, "R11", {30'b0, rsp_valid, exc_valid}, 32'h0);

        // Directed corner cases
        txn(32'h9F80_0013, 0, 1'b0, 0, 1'b0);             // R5/R9 byte read, lane 3, segment 4
        txn(32'h1F80_0102, 1, 1'b0, 0, 1'b0);             // R9 upper halfword
        txn(32'h1F80_0041, 0, 1'b1, 32'hFFFF_FFA5, 1'b0); // R9 byte store, lane 1
        txn(32'h1F80_0040, 2, 1'b0, 0, 1'b0);             // R9 read back the merged word
        txn(32'h0000_0103, 0, 1'b0, 0, 1'b0);             // R3 odd byte, no fault
        txn(32'hC000_0006, 2, 1'b0, 0, 1'b0);             // R1 misaligned word in segment 6 (alignment wins)
        txn(32'h8000_0011, 1, 1'b1, 0, 1'b0);             // R1 store alignment code, R2 latch
        txn(32'h2000_0010, 2, 1'b0, 0, 1'b0);             // R4 segment 1; R2 bad_addr unchanged
        txn(32'h0060_0004, 2, 1'b0, 0, 1'b0);             // R6 mirror
        txn(32'hBFC0_1002, 1, 1'b0, 0, 1'b0);             // R7 ROM read via segment 5
        txn(32'h9FC0_0000, 2, 1'b1, 32'h1234, 1'b0);      // R7 ROM write rejected
        txn(32'hBF80_0000, 2, 1'b0, 0, 1'b0);             // R5/R8 segment 5 skips scratchpad
        txn(32'h8000_0200, 2, 1'b1, 32'hDEAD, 1'b1);      // R10 bus error on RAM store
        txn(32'h1F80_0008, 2, 1'b0, 0, 1'b1);             // R10 flag ignored for scratchpad

        // Constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] ph, a;
            int pick, sz;
            logic [2:0] sg;
            case ($urandom % 5)
                0: ph = $urandom & 32'h007F_FFFF;
                1: ph = 32'h1F80_0000 | ($urandom & 32'h3FF);
                2: ph = 32'h1FC0_0000 | ($urandom & 32'h7_FFFF);
                3: ph = 32'h1F00_0000 | ($urandom & 32'hF_FFFF);
                default: ph = $urandom & 32'h1FFF_FFFF;
            endcase
            pick = $urandom % 12;
            sg = (pick < 4) ? 3'd0 : (pick < 7) ? 3'd4 : (pick < 10) ? 3'd5 : 3'($urandom);
            sz = $urandom % 3;
            a = {sg, ph[28:0]};
            if (($urandom % 4) != 0) a = (sz == 2) ? (a & ~32'h3) : (sz == 1) ? (a & ~32'h1) : a;
            txn(a, sz, 1'($urandom), $urandom, ($urandom % 8) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule